// File: doc/BRIEF.md
# Nibble-Wide DRAM Byte Read Sequencer

This block reads one byte from a dynamic RAM that is only four bits wide. Every byte costs one access slot of eight fast-clock phases (a 2 MHz slot on a 16 MHz clock). During the slot the row strobe goes low once. The column strobe pulses twice inside that single row-strobe window, so two half-bytes come from the same row. The two column addresses differ only in their least significant bit: a 0 fetches the low half-byte and a 1 fetches the high half-byte. The block joins the two halves into one byte and marks it with a one-cycle valid pulse.

The phase counter runs freely from reset. A request is taken only on the clock edge that opens phase 0. The byte address is captured on that edge, so the caller may change it once the request has been taken. A requester that keeps its request high gets one byte in every slot. Writes, refresh and arbitration are handled elsewhere.

Top module: `nib_dram_seq`

## Requirements
- R1: While reset is held low, ras_n_o and cas_n_o are 1, valid_o is 0 and byte_o is 0. The phase counter restarts at phase 0, and the first edge after release moves it to phase 1.
- R2: In an accepted slot, ras_n_o is 0 for phases 0 to 3 and 1 for phases 4 to 7. Outside accepted slots ras_n_o stays 1.
- R3: In an accepted slot, cas_n_o is 0 in phases 1 and 3 only, and at all other times it is 1. cas_n_o is never 0 while ras_n_o is 1.
- R4: In phase 0 of an accepted slot, ma_o carries the row {1'b0, A[15:8]}. In phase 1 it carries the column {A[7:0], 1'b0}, and in phases 2 and 3 it carries {A[7:0], 1'b1}, where A is the captured address.
- R5: dq_i is sampled on the edge that ends phase 1 (the low half-byte) and on the edge that ends phase 3 (the high half-byte). byte_o then equals {high, low}.
- R6: valid_o is 1 for exactly one cycle, in phase 4 of each accepted slot. byte_o holds its value until the next valid pulse.
- R7: req_i is sampled only on the edge from phase 7 to phase 0. A request raised at any other phase does not start a slot before the next phase 0.
- R8: A change on addr_i after the request has been taken has no effect on the row or column addresses of that slot, or on its result.
- R9: With req_i held high, consecutive slots start back to back, and their valid pulses are exactly 8 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock (16 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Byte read request |
| addr_i | input | 16 | Byte address |
| dq_i | input | 4 | Half-byte data from the RAM |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |
| ma_o | output | 9 | Multiplexed row/column address |
| valid_o | output | 1 | One-cycle pulse when byte_o is new |
| byte_o | output | 8 | Assembled byte |

## Verification
On every cycle the assertions check the following:
- each row-strobe fall and each slot start line up with the phase counter;
- the column strobe is always nested inside the row strobe;
- the column bit 0 is correct at each column strobe;
- the column address holds steady between the two strobes;
- valid is a single pulse in phase 4.

Only the bench scenarios can show the data behaviour:
- the assembled byte matches a modelled RAM for the captured address;
- late requests wait for the next slot;
- address changes after acceptance are ignored;
- held requests yield slots exactly eight cycles apart.

// File: rtl/nds_pkg.sv
package nds_pkg;
  // Phase positions inside one access slot; behaviour depends on this order.
  localparam int PH_ROW    = 0;  // row strobe falls
  localparam int PH_CAS_LO = 1;  // first column strobe, low half-byte
  localparam int PH_COL_HI = 2;  // column bit 0 flips to 1
  localparam int PH_CAS_HI = 3;  // second column strobe, high half-byte
  localparam int PH_DONE   = 4;  // row strobe released, byte valid
endpackage

// File: rtl/nds_phase.sv
module nds_phase #(
  parameter int PHASES = 8,
  parameter int PH_W   = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  output logic [PH_W-1:0] ph_o,
  output logic            act_o,
  output logic            start_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  function automatic logic [PH_W-1:0] next_phase(input logic [PH_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign start_o = req_i && (ph_o == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_o  <= '0;
      act_o <= 1'b0;
    end else begin
      ph_o <= next_phase(ph_o);
      if (ph_o == LAST) act_o <= req_i;
    end
  end
endmodule

// File: rtl/nds_strobe.sv
module nds_strobe
  import nds_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = ADDR_W / 2,
  parameter int MA_W   = ADDR_W - ROW_W + 1,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PH_W-1:0]   ph_i,
  input  logic              act_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic [MA_W-1:0]   ma_o
);
  localparam int COL_W = ADDR_W - ROW_W;

  logic [ADDR_W-1:0] addr_q;

  function automatic logic [MA_W-1:0] row_word(input logic [ADDR_W-1:0] a);
    return MA_W'(a[ADDR_W-1:COL_W]);
  endfunction

  function automatic logic [MA_W-1:0] col_word(input logic [ADDR_W-1:0] a, input logic hi);
    return {a[COL_W-1:0], hi};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (start_i) addr_q <= addr_i;
  end

  logic in_ras, col_ph, hi_sel;
  assign in_ras = act_i && (ph_i < PH_W'(PH_DONE));
  assign col_ph = act_i && (ph_i >= PH_W'(PH_CAS_LO)) && (ph_i <= PH_W'(PH_CAS_HI));
  assign hi_sel = (ph_i >= PH_W'(PH_COL_HI));

  assign ras_n_o = !in_ras;
  assign cas_n_o = !(act_i && ((ph_i == PH_W'(PH_CAS_LO)) || (ph_i == PH_W'(PH_CAS_HI))));
  assign ma_o    = col_ph ? col_word(addr_q, hi_sel) : row_word(addr_q);
endmodule

// File: rtl/nds_merge.sv
module nds_merge
  import nds_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int PH_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PH_W-1:0]    ph_i,
  input  logic               act_i,
  input  logic [NIB_W-1:0]   dq_i,
  output logic               cap_lo_o,
  output logic               cap_hi_o,
  output logic               valid_o,
  output logic [2*NIB_W-1:0] byte_o
);
  logic [NIB_W-1:0] lo_q;

  function automatic logic [2*NIB_W-1:0] join_halves(input logic [NIB_W-1:0] hi,
                                                     input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign cap_lo_o = act_i && (ph_i == PH_W'(PH_CAS_LO));
  assign cap_hi_o = act_i && (ph_i == PH_W'(PH_CAS_HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_hi_o;
      if (cap_lo_o) lo_q <= dq_i;
      if (cap_hi_o) byte_o <= join_halves(dq_i, lo_q);
    end
  end
endmodule

// File: rtl/nib_dram_seq.sv
module nib_dram_seq #(
  parameter int ADDR_W = 16,
  parameter int NIB_W  = 4,
  parameter int PHASES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NIB_W-1:0]              dq_i,
  output logic                          ras_n_o,
  output logic                          cas_n_o,
  output logic [ADDR_W-ADDR_W/2:0]      ma_o,
  output logic                          valid_o,
  output logic [2*NIB_W-1:0]            byte_o
);
  localparam int PH_W  = $clog2(PHASES);
  localparam int ROW_W = ADDR_W / 2;
  localparam int MA_W  = ADDR_W - ROW_W + 1;

  logic [PH_W-1:0] ph;
  logic            act, start, cap_lo, cap_hi;

  nds_phase #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .ph_o(ph), .act_o(act), .start_o(start)
  );

  nds_strobe #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .MA_W(MA_W), .PH_W(PH_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr_i),
    .ph_i(ph), .act_i(act),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .ma_o(ma_o)
  );

  nds_merge #(.NIB_W(NIB_W), .PH_W(PH_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .ph_i(ph), .act_i(act), .dq_i(dq_i),
    .cap_lo_o(cap_lo), .cap_hi_o(cap_hi), .valid_o(valid_o), .byte_o(byte_o)
  );
endmodule

// File: rtl/nds_checks.sv
module nds_checks
  import nds_pkg::*;
#(
  parameter int PH_W   = 3,
  parameter int MA_W   = 9,
  parameter int PHASES = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PH_W-1:0] ph,
  input logic            start,
  input logic            cap_lo,
  input logic            cap_hi,
  input logic            ras_n_o,
  input logic            cas_n_o,
  input logic [MA_W-1:0] ma_o,
  input logic            valid_o
);
  // R2: the row strobe only falls in phase 0
  p_ras_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (ph == PH_W'(PH_ROW)));

  // R3: column strobe nested inside the row strobe
  p_cas_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> !ras_n_o);

  // R4: column bit 0 selects the low half first, then the high half
  p_col_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lo |-> (!cas_n_o && !ma_o[0]));
  p_col_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |-> (!cas_n_o && ma_o[0]));

  // R8: upper column bits stay put across the two column strobes
  p_col_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hi |-> $stable(ma_o[MA_W-1:1]));

  // R6: valid is one cycle wide and lands in phase 4
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_valid_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (ph == PH_W'(PH_DONE)));

  // R7: a slot may only be opened from the last phase
  p_start_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (ph == PH_W'(PHASES - 1)));
endmodule

bind nib_dram_seq nds_checks #(.PH_W(PH_W), .MA_W(MA_W), .PHASES(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .start(start),
  .cap_lo(cap_lo), .cap_hi(cap_hi),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .ma_o(ma_o), .valid_o(valid_o)
);

// File: tb/nib_dram_seq_test.sv
`timescale 1ns/1ps
module nib_dram_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [3:0]  dq_i = '0;
  logic        ras_n_o, cas_n_o, valid_o;
  logic [8:0]  ma_o;
  logic [7:0]  byte_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  nib_dram_seq uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .dq_i(dq_i),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .ma_o(ma_o),
    .valid_o(valid_o), .byte_o(byte_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // RAM contents: a fixed mixing of row and column
  function automatic logic [3:0] ram_nib(input logic [7:0] row, input logic [8:0] col);
    logic [8:0] m;
    m = {1'b0, row} ^ (col * 9'd3) ^ (col >> 4);
    return m[3:0];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] a);
    return {ram_nib(a[15:8], {a[7:0], 1'b1}), ram_nib(a[15:8], {a[7:0], 1'b0})};
  endfunction

  // Bench view of slot timing, taken from the requirements
  logic [2:0]  bph = '0;
  logic        bact = 1'b0;
  logic [15:0] baddr = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      bph <= '0; bact <= 1'b0;
    end else begin
      bph <= bph + 3'd1;
      if (bph == 3'd7) begin
        bact <= req_i;
        if (req_i) baddr <= addr_i;
      end
    end
  end

  logic [7:0] expq[$];
  logic       ras_prev = 1'b1, cas_prev = 1'b1;
  logic [7:0] row_l = '0;
  logic [8:0] col_l = '0;
  logic [7:0] last_byte = '0;
  int         n_valid = 0;
  int         v_cyc_prev = 0, v_cyc_last = 0;

  // RAM model and monitor, away from the active edge
  always @(negedge clk) begin
    if (!ras_n_o && ras_prev) row_l = ma_o[7:0];
    if (!cas_n_o && cas_prev) col_l = ma_o;
    ras_prev = ras_n_o;
    cas_prev = cas_n_o;
    dq_i = cas_n_o ? 4'h0 : ram_nib(row_l, col_l);

    if (rst_n) begin
      chk(ras_n_o == !(bact && bph < 3'd4), "R2 ras_n", ras_n_o, !(bact && bph < 3'd4));
      chk(cas_n_o == !(bact && (bph == 3'd1 || bph == 3'd3)), "R3 cas_n",
          cas_n_o, !(bact && (bph == 3'd1 || bph == 3'd3)));
      if (bact && bph == 3'd0)
        chk(ma_o == {1'b0, baddr[15:8]}, "R4 row addr", ma_o, {1'b0, baddr[15:8]});
      if (bact && bph >= 3'd1 && bph <= 3'd3)
        chk(ma_o == {baddr[7:0], bph >= 3'd2}, "R4/R8 col addr", ma_o,
            {baddr[7:0], bph >= 3'd2});
      chk(valid_o == (bact && bph == 3'd4), "R6 valid timing", valid_o, bact && bph == 3'd4);
      if (valid_o) begin
        n_valid++;
        v_cyc_prev = v_cyc_last;
        v_cyc_last = cyc;
        if (expq.size() == 0) chk(1'b0, "R5 unexpected byte", byte_o, 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(byte_o == e, "R5 byte", byte_o, e);
        end
        last_byte = byte_o;
      end else if (n_valid > 0) begin
        chk(byte_o == last_byte, "R6 byte hold", byte_o, last_byte);
      end
    end
  end

  // Driver: wait d cycles, raise a request, push the expected byte once taken
  task automatic issue(input logic [15:0] a, input int d, input bit keep);
    repeat (d) @(negedge clk);
    req_i = 1'b1;
    addr_i = a;
    while (bph != 3'd7) @(negedge clk);
    @(negedge clk);
    expq.push_back(exp_byte(a));
    chk(bph == 3'd0 && bact, "R7 taken at phase 0", bph, 0);
    addr_i = ~a;
    if (!keep) req_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ras_n_o == 1'b1, "R1 ras_n in reset", ras_n_o, 1);
    chk(cas_n_o == 1'b1, "R1 cas_n in reset", cas_n_o, 1);
    chk(valid_o == 1'b0, "R1 valid in reset", valid_o, 0);
    chk(byte_o == 8'h00, "R1 byte in reset", byte_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bph == 3'd3 && ras_n_o, "R1 idle after reset", ras_n_o, 1);

    issue(16'h0000, 0, 1'b0);
    issue(16'hFFFF, 1, 1'b0);
    issue(16'h1234, 3, 1'b0);
    // R7: late request raised mid-slot waits for the next phase 0
    while (bph != 3'd2) @(negedge clk);
    issue(16'hA55A, 0, 1'b0);
    while (bph != 3'd5) @(negedge clk);
    issue(16'h0F0F, 0, 1'b0);
    // R9: held request, back-to-back slots
    issue(16'h8001, 2, 1'b1);
    issue(16'h7E3C, 0, 1'b0);
    repeat (12) @(negedge clk);
    chk(v_cyc_last - v_cyc_prev == 8, "R9 back-to-back spacing", v_cyc_last - v_cyc_prev, 8);
    chk(expq.size() == 0, "R6 all bytes delivered", expq.size(), 0);
    chk(n_valid == 7, "R6 valid count", n_valid, 7);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule